// File: doc/BRIEF.md
# Descriptor-driven configuration DMA engine

This block lets firmware pull configuration items out of a small item store and into system memory without moving them a byte at a time through a register. Software places a 16-byte descriptor in memory and rings a doorbell with that descriptor's address. The engine fetches the descriptor and may switch to a new item. It then copies bytes from the item's current read position into memory, or steps over them. When it finishes, it writes a status word back over the descriptor's control field.

The item store sits outside the block. The engine gives it a key and a read offset. The store returns whether the item exists and holds data, its length, and the byte at that offset. The memory side is a byte-wide master: one request per byte, held until acknowledged, with an error response. The current key and offset persist between transfers, so several descriptors can walk through one item in pieces.

Top module: `cfg_dma_engine`

## Requirements
- R1: Doorbell writes carry big-endian values, with the first byte of the access in reg_wdata[63:56]. A 4-byte write at offset 0 loads the upper address half from reg_wdata[63:32]. A 4-byte write at offset 4 supplies the lower half and starts a transfer. An 8-byte write at offset 0 supplies the whole address from reg_wdata and starts a transfer.
- R2: Every other access, including any read, pulses reg_rej for one cycle and starts nothing.
- R3: The stored upper address half returns to zero whenever a transfer starts.
- R4: The descriptor is fetched as 16 byte reads from ascending addresses. In byte order the fields are: a 32-bit control word, a 32-bit length, then a 64-bit destination address. Each field is big-endian.
- R5: Control bit 3 set selects item key = control[31:16] and resets the item offset to 0.
- R6: Control bit 1 (read) wins over bit 2 (skip). With neither set, the length is treated as zero and no data moves.
- R7: A read copies min(remaining, item length - offset) bytes to ascending destination addresses and advances the item offset by the same amount. A later transfer continues from that offset.
- R8: If the item is absent, has no data, or the offset is at or past its length, a read writes zeros for all remaining bytes. A skip then issues no memory access and leaves the offset unchanged. A skip inside an item advances the offset without memory writes.
- R9: On completion the engine writes 4 bytes at the descriptor address: 00 00 00 00, or 00 00 00 01 if a memory access failed. Data movement stops at the first failed write.
- R10: If a descriptor read fails, the engine moves no data and writes only 00 00 00 01 to the control field.
- R11: busy is high from the start of a transfer until done. Doorbell writes during that time are ignored. done is a one-cycle pulse after the last status byte is acknowledged.
- R12: dev_id reads 3 when DMA is enabled (bit 1 and bit 0), otherwise 1.
- R13: A memory request keeps its address and direction stable until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Doorbell write strobe |
| reg_rd | input | 1 | Doorbell read strobe (always rejected) |
| reg_ofs | input | 3 | Byte offset of the access |
| reg_bytes | input | 4 | Access size in bytes |
| reg_wdata | input | 64 | Write data, first byte in the top lane |
| reg_rej | output | 1 | One-cycle pulse for a rejected access |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |
| mem_ack | input | 1 | Request acknowledged |
| mem_err | input | 1 | Error response, valid with mem_ack |
| item_key | output | 16 | Currently selected item key |
| item_ofs | output | 32 | Current read offset in the item |
| item_ok | input | 1 | Item exists and holds data |
| item_len | input | 32 | Item length in bytes |
| item_byte | input | 8 | Item byte at item_ofs |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| dev_id | output | 32 | Device identification value |

## Verification
The copy path runs with a read that ends inside an item, a read that runs past the end and must switch to zero fill partway through, and a read that continues from an offset left behind by an earlier transfer. Each of these places the boundary between copied and zeroed bytes somewhere different. Skips are tried inside an item, on an item with no data and on an unselected key, which separates an advancing offset from a frozen one. Flag combinations with both read and skip set, or neither set, check the priority rule. Failures injected on a data write and on a descriptor byte show whether the status byte carries the error, and whether data movement stops or never starts.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DECODE, S_STEP, S_MOVE, S_STAT
  } seq_state_t;

  localparam int CTL_ERR    = 0;
  localparam int CTL_RD     = 1;
  localparam int CTL_SKIP   = 2;
  localparam int CTL_SEL    = 3;
  localparam int DESC_BYTES = 16;
  localparam int STAT_BYTES = 4;
endpackage

// File: rtl/cfgdma_doorbell.sv
module cfgdma_doorbell #(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_ofs,
  input  logic [3:0]        reg_bytes,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic              start,
  output logic [ADDR_W-1:0] start_addr,
  output logic              reg_rej
);
  localparam int HALF = ADDR_W / 2;

  logic [HALF-1:0] upper_q;
  logic is_hi, is_lo, is_full, legal, take;

  assign is_hi   = reg_wr && reg_bytes == 4'd4 && reg_ofs == 3'd0;
  assign is_lo   = reg_wr && reg_bytes == 4'd4 && reg_ofs == 3'd4;
  assign is_full = reg_wr && reg_bytes == 4'd8 && reg_ofs == 3'd0;
  assign legal   = is_hi || is_lo || is_full;
  assign take    = !busy && !start;

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q    <= '0;
      start      <= 1'b0;
      start_addr <= '0;
      reg_rej    <= 1'b0;
    end else begin
      start   <= 1'b0;
      reg_rej <= (reg_wr || reg_rd) && !legal;
      if (take) begin
        if (is_hi) upper_q <= reg_wdata[ADDR_W-1 -: HALF];
        if (is_lo) begin
          start      <= 1'b1;
          start_addr <= {upper_q, reg_wdata[ADDR_W-1 -: HALF]};
          upper_q    <= '0;
        end
        if (is_full) begin
          start      <= 1'b1;
          start_addr <= reg_wdata;
          upper_q    <= '0;
        end
      end
    end
  end

  logic unused_lo;
  assign unused_lo = ^reg_wdata[HALF-1:0];
endmodule

// File: rtl/cfgdma_span.sv
module cfgdma_span #(
  parameter int LEN_W = 32
) (
  input  logic [LEN_W-1:0] rem,
  input  logic [LEN_W-1:0] ofs,
  input  logic [LEN_W-1:0] item_len,
  input  logic             item_ok,
  output logic [LEN_W-1:0] span,
  output logic             past_end
);
  logic [LEN_W-1:0] left;

  assign left     = item_len - ofs;
  assign past_end = !item_ok || (ofs >= item_len);
  assign span     = past_end ? rem : ((rem < left) ? rem : left);
endmodule

// File: rtl/cfgdma_seq.sv
module cfgdma_seq
  import cfgdma_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32,
  parameter int KEY_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic [KEY_W-1:0]  item_key,
  output logic [LEN_W-1:0]  item_ofs,
  input  logic              item_ok,
  input  logic [LEN_W-1:0]  item_len,
  input  logic [7:0]        item_byte,
  output logic              busy,
  output logic              done
);
  localparam int DBW   = DESC_BYTES * 8;
  localparam int IDX_W = $clog2(DESC_BYTES);

  seq_state_t       st;
  logic [IDX_W-1:0] idx;
  logic [ADDR_W-1:0] desc, dst;
  logic [DBW-1:0]   dbuf;
  logic [LEN_W-1:0] rem, cnt, span;
  logic             rd_mode, zero, err, past_end;

  logic [31:0]       d_ctl;
  logic [LEN_W-1:0]  d_len;
  logic [ADDR_W-1:0] d_dst;
  assign d_ctl = dbuf[DBW-1 -: 32];
  assign d_len = dbuf[DBW-33 -: LEN_W];
  assign d_dst = dbuf[ADDR_W-1:0];

  cfgdma_span #(.LEN_W(LEN_W)) u_span (
    .rem(rem), .ofs(item_ofs), .item_len(item_len), .item_ok(item_ok),
    .span(span), .past_end(past_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      idx      <= '0;
      desc     <= '0;
      dst      <= '0;
      dbuf     <= '0;
      rem      <= '0;
      cnt      <= '0;
      rd_mode  <= 1'b0;
      zero     <= 1'b0;
      err      <= 1'b0;
      done     <= 1'b0;
      item_key <= '1;
      item_ofs <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          desc <= start_addr;
          idx  <= '0;
          err  <= 1'b0;
          st   <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          if (mem_err) begin
            err <= 1'b1;
            idx <= '0;
            st  <= S_STAT;
          end else begin
            dbuf <= {dbuf[DBW-9:0], mem_rdata};
            idx  <= idx + IDX_W'(1);
            if (idx == IDX_W'(DESC_BYTES - 1)) st <= S_DECODE;
          end
        end
        S_DECODE: begin
          dst     <= d_dst;
          rd_mode <= d_ctl[CTL_RD];
          rem     <= (d_ctl[CTL_RD] || d_ctl[CTL_SKIP]) ? d_len : '0;
          if (d_ctl[CTL_SEL]) begin
            item_key <= d_ctl[31 -: KEY_W];
            item_ofs <= '0;
          end
          st <= S_STEP;
        end
        S_STEP: begin
          if (rem == '0) begin
            idx <= '0;
            st  <= S_STAT;
          end else if (rd_mode) begin
            cnt  <= span;
            zero <= past_end;
            st   <= S_MOVE;
          end else begin
            dst <= dst + ADDR_W'(span);
            rem <= rem - span;
            if (!past_end) item_ofs <= item_ofs + span;
          end
        end
        S_MOVE: if (mem_ack) begin
          if (mem_err) begin
            err <= 1'b1;
            idx <= '0;
            st  <= S_STAT;
          end else begin
            dst <= dst + ADDR_W'(1);
            rem <= rem - LEN_W'(1);
            cnt <= cnt - LEN_W'(1);
            if (!zero) item_ofs <= item_ofs + LEN_W'(1);
            if (cnt == LEN_W'(1)) st <= S_STEP;
          end
        end
        S_STAT: if (mem_ack) begin
          idx <= idx + IDX_W'(1);
          if (idx == IDX_W'(STAT_BYTES - 1)) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign mem_req  = (st == S_FETCH) || (st == S_MOVE) || (st == S_STAT);
  assign mem_we   = (st == S_MOVE) || (st == S_STAT);
  assign mem_addr = (st == S_MOVE) ? dst : desc + ADDR_W'(idx);
  always_comb begin
    if (st == S_STAT)
      mem_wdata = (idx == IDX_W'(STAT_BYTES - 1)) ? {7'b0, err} : 8'h00;
    else
      mem_wdata = zero ? 8'h00 : item_byte;
  end

  logic unused_ctl;
  assign unused_ctl = ^{d_ctl[31-KEY_W:CTL_SEL+1], d_ctl[CTL_ERR]};
endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine #(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32,
  parameter int KEY_W  = 16,
  parameter bit DMA_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_ofs,
  input  logic [3:0]        reg_bytes,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic              reg_rej,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic [KEY_W-1:0]  item_key,
  output logic [LEN_W-1:0]  item_ofs,
  input  logic              item_ok,
  input  logic [LEN_W-1:0]  item_len,
  input  logic [7:0]        item_byte,
  output logic              busy,
  output logic              done,
  output logic [31:0]       dev_id
);
  localparam logic [31:0] ID_VAL = DMA_EN ? 32'd3 : 32'd1;

  logic              start;
  logic [ADDR_W-1:0] start_addr;

  assign dev_id = ID_VAL;

  cfgdma_doorbell #(.ADDR_W(ADDR_W)) u_bell (
    .clk(clk), .rst(rst), .busy(busy),
    .reg_wr(reg_wr && DMA_EN), .reg_rd(reg_rd), .reg_ofs(reg_ofs),
    .reg_bytes(reg_bytes), .reg_wdata(reg_wdata),
    .start(start), .start_addr(start_addr), .reg_rej(reg_rej)
  );

  cfgdma_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .KEY_W(KEY_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_err(mem_err), .item_key(item_key), .item_ofs(item_ofs),
    .item_ok(item_ok), .item_len(item_len), .item_byte(item_byte),
    .busy(busy), .done(done)
  );
endmodule

// File: rtl/cfgdma_checker.sv
module cfgdma_checker #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic              reg_rej,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              busy,
  input logic              done
);
  assert_req_hold_R13: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_req_in_busy_R11: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  assert_fall_done_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_rej_cause_R2: assert property (@(posedge clk) disable iff (rst)
    reg_rej |-> $past(reg_wr || reg_rd));

  assert_start_cause_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(reg_wr, 2));
endmodule

bind cfg_dma_engine cfgdma_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rej(reg_rej),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_ack(mem_ack), .busy(busy), .done(done)
);

// File: tb/sim_cfg_dma_engine.sv
module sim_cfg_dma_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 0, reg_rd = 0;
  logic [2:0]  reg_ofs = 0;
  logic [3:0]  reg_bytes = 0;
  logic [63:0] reg_wdata = 0;
  logic        reg_rej;
  logic        mem_req, mem_we;
  logic [63:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_ack, mem_err;
  logic [15:0] item_key;
  logic [31:0] item_ofs;
  logic        item_ok;
  logic [31:0] item_len;
  logic [7:0]  item_byte;
  logic        busy, done;
  logic [31:0] dev_id;

  always #5 clk = ~clk;

  cfg_dma_engine u0 (.*);

  int checks = 0, errors = 0, done_cnt = 0;
  bit finished = 0;
  string cur_tag = "";

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // item store: key 0 = 8 bytes A0.., key 1 = 3 bytes 10.., others absent
  assign item_ok   = (item_key <= 16'd1);
  assign item_len  = (item_key == 16'd0) ? 32'd8 : (item_key == 16'd1) ? 32'd3 : 32'd0;
  assign item_byte = ((item_key == 16'd0) ? 8'hA0 : 8'h10) + item_ofs[7:0];

  // memory model
  logic [7:0]  mem [logic [63:0]];
  logic        err_en = 0;
  logic [63:0] err_addr = 0;
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 0; mem_err <= 0; mem_rdata <= 0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        mem_err   <= err_en && mem_addr == err_addr;
        mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
        if (mem_we && !(err_en && mem_addr == err_addr)) mem[mem_addr] = mem_wdata;
      end
    end
  end

  // scoreboard
  logic [63:0] exp_a [$];
  logic [7:0]  exp_d [$];
  always @(negedge clk) begin
    if (!rst && mem_req && mem_ack && mem_we) begin
      if (exp_a.size() == 0) chk(0, {cur_tag, " R9 unexpected write"}, mem_addr, 0);
      else begin
        logic [63:0] a;
        logic [7:0]  d;
        a = exp_a.pop_front();
        d = exp_d.pop_front();
        chk(mem_addr == a && mem_wdata == d, cur_tag, {mem_addr[55:0], mem_wdata}, {a[55:0], d});
      end
    end
    if (done) done_cnt++;
  end

  task automatic push(logic [63:0] a, logic [7:0] d);
    exp_a.push_back(a); exp_d.push_back(d);
  endtask
  task automatic push_stat(logic [63:0] a, bit e);
    for (int i = 0; i < 3; i++) push(a + i, 8'h00);
    push(a + 3, {7'b0, e});
  endtask
  task automatic put_desc(logic [63:0] a, logic [31:0] ctl, logic [31:0] len, logic [63:0] dst);
    logic [127:0] v;
    v = {ctl, len, dst};
    for (int i = 0; i < 16; i++) mem[a + i] = v[127 - 8*i -: 8];
  endtask
  task automatic ring(bit wr, bit rd, logic [2:0] o, logic [3:0] b, logic [63:0] d, output bit rej);
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_ofs = o; reg_bytes = b; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_rd = 0;
    rej = reg_rej;
  endtask
  task automatic go64(logic [63:0] a);
    bit r;
    ring(1, 0, 0, 8, a, r);
  endtask
  task automatic wait_done(string tag);
    int n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    chk(n < 3000, {tag, " R11 done seen"}, n, 0);
    chk(!busy, {tag, " R11 busy low at done"}, busy, 0);
    @(negedge clk);
    chk(!done, {tag, " R11 done one cycle"}, done, 0);
    chk(exp_a.size() == 0, {tag, " R9 all writes seen"}, exp_a.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit r;
    int dc;
    logic [31:0] ofs_keep;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy && !done && !mem_req, "reset idle", {busy, done, mem_req}, 0);
    chk(dev_id == 32'd3, "R12 dev_id", dev_id, 3);
    chk(item_key == 16'hFFFF, "reset key", item_key, 16'hFFFF);

    // R4 R5 R7: 64-bit doorbell, select key 0, read 5
    cur_tag = "R7 read in item";
    put_desc(64'h1000, 32'h0000_000A, 5, 64'h2000);
    for (int i = 0; i < 5; i++) push(64'h2000 + i, 8'hA0 + i);
    push_stat(64'h1000, 0);
    go64(64'h1000);
    wait_done(cur_tag);
    chk(item_ofs == 5, "R7 offset advance", item_ofs, 5);
    chk(item_key == 0, "R5 key select", item_key, 0);

    // R1 R8: 32-bit halves, continue and run past end
    cur_tag = "R8 read past end";
    put_desc(64'h1100, 32'h2, 6, 64'h3000);
    for (int i = 0; i < 3; i++) push(64'h3000 + i, 8'hA5 + i);
    for (int i = 3; i < 6; i++) push(64'h3000 + i, 8'h00);
    push_stat(64'h1100, 0);
    ring(1, 0, 0, 4, 64'h0, r);
    chk(!busy, "R1 upper write no start", busy, 0);
    ring(1, 0, 4, 4, {32'h0000_1100, 32'h0}, r);
    wait_done(cur_tag);
    chk(item_ofs == 8, "R8 offset at end", item_ofs, 8);

    // R8 skip inside item, then read the rest
    cur_tag = "R8 skip in item";
    put_desc(64'h1200, 32'h0001_000C, 2, 64'h4000);
    push_stat(64'h1200, 0);
    go64(64'h1200);
    wait_done(cur_tag);
    chk(item_ofs == 2, "R8 skip advances offset", item_ofs, 2);
    cur_tag = "R7 continue after skip";
    put_desc(64'h1220, 32'h2, 4, 64'h4100);
    push(64'h4100, 8'h12);
    for (int i = 1; i < 4; i++) push(64'h4100 + i, 8'h00);
    push_stat(64'h1220, 0);
    go64(64'h1220);
    wait_done(cur_tag);
    chk(item_ofs == 3, "R7 offset after continue", item_ofs, 3);

    // R6 read wins over skip
    cur_tag = "R6 read over skip";
    put_desc(64'h1240, 32'h0000_000E, 2, 64'h4200);
    push(64'h4200, 8'hA0); push(64'h4201, 8'hA1);
    push_stat(64'h1240, 0);
    go64(64'h1240);
    wait_done(cur_tag);
    chk(item_ofs == 2, "R6 read over skip offset", item_ofs, 2);

    // R6 neither flag: select only, no data
    cur_tag = "R6 no flag";
    put_desc(64'h1260, 32'h0001_0008, 4, 64'h4300);
    push_stat(64'h1260, 0);
    go64(64'h1260);
    wait_done(cur_tag);
    chk(item_key == 1 && item_ofs == 0, "R6 select without move", {item_key, item_ofs}, {16'd1, 32'd0});

    // R8 absent key read zero-fills, empty key skip
    cur_tag = "R8 absent read";
    put_desc(64'h1280, 32'h0005_000A, 2, 64'h4400);
    push(64'h4400, 8'h00); push(64'h4401, 8'h00);
    push_stat(64'h1280, 0);
    go64(64'h1280);
    wait_done(cur_tag);
    cur_tag = "R8 empty skip";
    put_desc(64'h12A0, 32'h0002_000C, 7, 64'h4500);
    push_stat(64'h12A0, 0);
    go64(64'h12A0);
    wait_done(cur_tag);
    chk(item_ofs == 0, "R8 empty skip offset", item_ofs, 0);

    // R2 rejects
    ring(1, 0, 0, 2, 64'h1000, r); chk(r, "R2 size 2 rejected", r, 1);
    ring(0, 1, 0, 4, 64'h0, r);    chk(r, "R2 read rejected", r, 1);
    ring(1, 0, 2, 4, 64'h0, r);    chk(r, "R2 offset 2 rejected", r, 1);
    ring(1, 0, 4, 8, 64'h1000, r); chk(r, "R2 8 at 4 rejected", r, 1);
    repeat (20) @(negedge clk);
    chk(!busy && exp_a.size() == 0, "R2 no start", busy, 0);

    // R3 upper half cleared after start
    cur_tag = "R3 first";
    put_desc(64'h1_0000_1500, 32'h0001_000A, 1, 64'h4600);
    push(64'h4600, 8'h10);
    push_stat(64'h1_0000_1500, 0);
    ring(1, 0, 0, 4, {32'h1, 32'h0}, r);
    chk(!r, "R1 legal not rejected", r, 0);
    ring(1, 0, 4, 4, {32'h0000_1500, 32'h0}, r);
    wait_done(cur_tag);
    cur_tag = "R3 cleared upper";
    put_desc(64'h1600, 32'h2, 1, 64'h4700);
    push(64'h4700, 8'h11);
    push_stat(64'h1600, 0);
    ring(1, 0, 4, 4, {32'h0000_1600, 32'h0}, r);
    wait_done(cur_tag);

    // R11 doorbell ignored while busy
    cur_tag = "R11 ignore while busy";
    put_desc(64'h1700, 32'h0000_000A, 4, 64'h4800);
    put_desc(64'h1800, 32'h0001_000A, 2, 64'h4900);
    for (int i = 0; i < 4; i++) push(64'h4800 + i, 8'hA0 + i);
    push_stat(64'h1700, 0);
    dc = done_cnt;
    go64(64'h1700);
    repeat (5) @(negedge clk);
    chk(busy, "R11 busy during transfer", busy, 1);
    go64(64'h1800);
    wait_done(cur_tag);
    repeat (60) @(negedge clk);
    chk(!busy && done_cnt == dc + 1, "R11 one transfer only", done_cnt - dc, 1);

    // R9 data write error stops the loop
    cur_tag = "R9 write error";
    err_en = 1; err_addr = 64'h4A01;
    put_desc(64'h1900, 32'h0000_000A, 4, 64'h4A00);
    push(64'h4A00, 8'hA0); push(64'h4A01, 8'hA1);
    push_stat(64'h1900, 1);
    go64(64'h1900);
    wait_done(cur_tag);
    ofs_keep = item_ofs;

    // R10 descriptor fetch error
    cur_tag = "R10 fetch error";
    err_addr = 64'h1A05;
    put_desc(64'h1A00, 32'h0001_000A, 3, 64'h4B00);
    push_stat(64'h1A00, 1);
    go64(64'h1A00);
    wait_done(cur_tag);
    chk(item_ofs == ofs_keep && item_key == 0, "R10 state untouched", item_ofs, ofs_keep);
    err_en = 0;

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule